// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and a calendar date: seconds, minutes, hours, day of month, day of week, month and a 12-bit year. A one-second tick input advances it. Software reaches it through a simple memory-mapped register bus with a write strobe, an address, write data and combinational read data.

New values go in through two set registers, one for the time of day and one for the date. Each takes a short control handshake: software raises a freeze bit, then raises a capture bit alongside it, drops the capture bit, and finally drops the freeze bit. The value is taken on the write in which capture rises while freeze is held. Counting stops while either register's freeze bit is held. The year is written directly through its own register. The running values are read back through two read-only registers whose field layout is different from the layout of the set registers. Weekdays count 1 to 7, with Sunday encoded as 7. February has 29 days in every year whose value is divisible by 4. This is a deliberate simplification of the leap-year rule.

All counters update on the same clock edge, so a read never sees a half-propagated carry.

Top module: `cal_clock_top`

## Requirements
- R1: An active-high synchronous reset sets the time to 00:00:00 and the date to day 1, month 1, weekday 1, year 0.
- R2: Offset 0x10 reads the current time as hours in bits 20:16, minutes in bits 13:8 and seconds in bits 5:0. Offset 0x14 reads the current date as month in 27:24, weekday in 23:21, day of month in 20:16 and year in 11:0. Every other offset reads as zero, and so do all unused bits.
- R3: Each tick that is not frozen adds one to the seconds. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0.
- R4: The hour wrap advances the day of month and the weekday on the same edge. The weekday wraps from 7 to 1.
- R5: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except 2. Month 12 wraps to month 1 and the year goes up by one on the same edge.
- R6: February ends after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R7: A write to the time-set register (0x00) or the date-set register (0x04) loads its value when it has bit 25 (capture) and bit 24 (freeze) both at 1, and the previous write to that register had bit 25 at 0. The time-set fields are hours 20:16, minutes 13:8 and seconds 5:0. The date-set fields are month 19:16, weekday 10:8 and day of month 4:0.
- R8: A write that carries capture when the previous write to the same register also carried capture does not reload.
- R9: From the cycle after a write with bit 24 at 1 to either set register, until a write clears bit 24 on every set register, ticks are ignored and the time and date hold.
- R10: A write to offset 0x08 loads bits 11:0 directly into the year. It takes priority over a year carry on the same edge.
- R11: Bits of the set registers outside the fields and control bits do not affect the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-second advance pulse, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench drives the clock through a New Year's Eve midnight. A design with a broken carry chain would leave the month at 12, fail to move the year, or move the weekday past 7 instead of back to 1. It steps through the end of February in a divisible year and in a non-divisible year, and through the end of a 30-day month; a wrong month-length function skips or adds a day. It repeats the capture bit without dropping it and holds the freeze bit across many ticks; a level-sensitive capture would reload the second value, and a missing freeze would let the seconds drift. It also loads a time word full of stray bits and reads unmapped offsets, which exposes field masks that are shifted or too wide.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DATA_W = 32;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DOM_W  = 5;
    localparam int WD_W   = 3;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 12;

    localparam int OFS_TSET  = 'h00;
    localparam int OFS_DSET  = 'h04;
    localparam int OFS_YEAR  = 'h08;
    localparam int OFS_CTIME = 'h10;
    localparam int OFS_CDATE = 'h14;

    localparam int BIT_FREEZE  = 24;
    localparam int BIT_CAPTURE = 25;
    localparam int N_SETREG    = 2;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);
    localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(7);
    localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } tod_t;

    typedef struct packed {
        logic [MON_W-1:0] mon;
        logic [WD_W-1:0]  wd;
        logic [DOM_W-1:0] dom;
    } mdw_t;

    typedef struct packed {
        logic [YEAR_W-1:0] yr;
        mdw_t              md;
    } cal_t;

    function automatic logic [DOM_W-1:0] month_len(logic [MON_W-1:0] mon,
                                                   logic [YEAR_W-1:0] yr);
        logic [DOM_W-1:0] n;
        case (mon)
            MON_W'(2):  n = (yr[1:0] == 2'b00) ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): n = DOM_W'(30);
            default:    n = DOM_W'(31);
        endcase
        return n;
    endfunction

    function automatic tod_t tod_from_set(logic [DATA_W-1:0] w);
        tod_t t;
        t.hr = w[20:16];
        t.mn = w[13:8];
        t.sc = w[5:0];
        return t;
    endfunction

    function automatic mdw_t mdw_from_set(logic [DATA_W-1:0] w);
        mdw_t d;
        d.mon = w[19:16];
        d.wd  = w[10:8];
        d.dom = w[4:0];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] tod_word(tod_t t);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[20:16] = t.hr;
        w[13:8]  = t.mn;
        w[5:0]   = t.sc;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] cal_word(cal_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[27:24] = c.md.mon;
        w[23:21] = c.md.wd;
        w[20:16] = c.md.dom;
        w[11:0]  = c.yr;
        return w;
    endfunction

endpackage

// File: rtl/cal_regif.sv
module cal_regif
    import cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ld_time,
    output logic              ld_date,
    output logic              ld_year,
    output tod_t              time_val,
    output mdw_t              date_val,
    output logic [YEAR_W-1:0] year_val,
    output logic              paused
);

    logic [N_SETREG-1:0] hit;
    logic [N_SETREG-1:0] cap;
    logic [N_SETREG-1:0] frz;

    assign hit[0] = bus_we && (bus_addr == ADDR_W'(OFS_TSET));
    assign hit[1] = bus_we && (bus_addr == ADDR_W'(OFS_DSET));

    for (genvar c = 0; c < N_SETREG; c++) begin : g_chan
        logic frz_q;
        logic cap_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                frz_q <= 1'b0;
                cap_q <= 1'b0;
            end else if (hit[c]) begin
                frz_q <= bus_wdata[BIT_FREEZE];
                cap_q <= bus_wdata[BIT_CAPTURE];
            end
        end
        assign frz[c] = frz_q;
        assign cap[c] = hit[c] && bus_wdata[BIT_FREEZE] && bus_wdata[BIT_CAPTURE] && !cap_q;
    end

    assign ld_time  = cap[0];
    assign ld_date  = cap[1];
    assign ld_year  = bus_we && (bus_addr == ADDR_W'(OFS_YEAR));
    assign time_val = tod_from_set(bus_wdata);
    assign date_val = mdw_from_set(bus_wdata);
    assign year_val = bus_wdata[YEAR_W-1:0];
    assign paused   = |frz;

endmodule

// File: rtl/cal_tod_cnt.sv
module cal_tod_cnt
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic ld,
    input  tod_t ld_val,
    output tod_t tod,
    output logic day_carry
);

    tod_t tod_q;

    logic sc_end;
    logic mn_end;
    logic hr_end;

    assign sc_end = (tod_q.sc >= SEC_LAST);
    assign mn_end = (tod_q.mn >= MIN_LAST);
    assign hr_end = (tod_q.hr >= HR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q <= '0;
        end else if (ld) begin
            tod_q <= ld_val;
        end else if (adv) begin
            if (sc_end) begin
                tod_q.sc <= '0;
                if (mn_end) begin
                    tod_q.mn <= '0;
                    tod_q.hr <= hr_end ? '0 : tod_q.hr + 1'b1;
                end else begin
                    tod_q.mn <= tod_q.mn + 1'b1;
                end
            end else begin
                tod_q.sc <= tod_q.sc + 1'b1;
            end
        end
    end

    assign tod       = tod_q;
    assign day_carry = adv && !ld && sc_end && mn_end && hr_end;

endmodule

// File: rtl/cal_date_cnt.sv
module cal_date_cnt
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              ld_date,
    input  mdw_t              date_val,
    input  logic              ld_year,
    input  logic [YEAR_W-1:0] year_val,
    output cal_t              cal
);

    cal_t cal_q;

    logic month_end;
    logic year_end;

    assign month_end = (cal_q.md.dom >= month_len(cal_q.md.mon, cal_q.yr));
    assign year_end  = month_end && (cal_q.md.mon >= MON_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q.md.dom <= DOM_W'(1);
            cal_q.md.mon <= MON_W'(1);
            cal_q.md.wd  <= WD_W'(1);
        end else if (ld_date) begin
            cal_q.md <= date_val;
        end else if (inc) begin
            cal_q.md.wd <= (cal_q.md.wd >= WD_LAST) ? WD_W'(1) : cal_q.md.wd + 1'b1;
            if (month_end) begin
                cal_q.md.dom <= DOM_W'(1);
                cal_q.md.mon <= (cal_q.md.mon >= MON_LAST) ? MON_W'(1) : cal_q.md.mon + 1'b1;
            end else begin
                cal_q.md.dom <= cal_q.md.dom + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q.yr <= '0;
        end else if (ld_year) begin
            cal_q.yr <= year_val;
        end else if (inc && !ld_date && year_end) begin
            cal_q.yr <= cal_q.yr + 1'b1;
        end
    end

    assign cal = cal_q;

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
    import cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1s,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic              ld_time;
    logic              ld_date;
    logic              ld_year;
    tod_t              time_val;
    mdw_t              date_val;
    logic [YEAR_W-1:0] year_val;
    logic              paused;
    logic              adv;
    logic              day_inc;
    tod_t              tod_q;
    cal_t              cal_q;

    cal_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ld_time  (ld_time),
        .ld_date  (ld_date),
        .ld_year  (ld_year),
        .time_val (time_val),
        .date_val (date_val),
        .year_val (year_val),
        .paused   (paused)
    );

    assign adv = tick_1s && !paused && !ld_time && !ld_date;

    cal_tod_cnt u_tod (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .ld       (ld_time),
        .ld_val   (time_val),
        .tod      (tod_q),
        .day_carry(day_inc)
    );

    cal_date_cnt u_date (
        .clk     (clk),
        .rst     (rst),
        .inc     (day_inc),
        .ld_date (ld_date),
        .date_val(date_val),
        .ld_year (ld_year),
        .year_val(year_val),
        .cal     (cal_q)
    );

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTIME)) begin
            bus_rdata = tod_word(tod_q);
        end else if (bus_addr == ADDR_W'(OFS_CDATE)) begin
            bus_rdata = cal_word(cal_q);
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1s,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              paused,
    input logic              ld_time,
    input logic              day_inc,
    input tod_t              tod,
    input cal_t              cal
);

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tod == '0) && (cal.md.dom == 5'd1) && (cal.md.mon == 4'd1)
                && (cal.md.wd == 3'd1) && (cal.yr == '0));

    // R9: frozen counters hold while no write arrives
    a_r9_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (paused && !bus_we) |=> $stable(tod) && $stable(cal));

    // R3: seconds wrap at 59
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick_1s && !paused && !bus_we && tod.sc == 6'd59) |=> (tod.sc == 6'd0));

    // R3: no tick and no write means nothing moves
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick_1s && !bus_we) |=> $stable(tod) && $stable(cal));

    // R4: weekday wraps from 7 to 1
    a_r4_wd_wrap: assert property (@(posedge clk) disable iff (rst)
        (day_inc && cal.md.wd == 3'd7) |=> (cal.md.wd == 3'd1));

    // R5: year end rolls month, day and year together
    a_r5_new_year: assert property (@(posedge clk) disable iff (rst)
        (day_inc && cal.md.mon == 4'd12 && cal.md.dom == 5'd31
         && !(bus_we && bus_addr == ADDR_W'(OFS_YEAR)))
        |=> (cal.md.mon == 4'd1) && (cal.md.dom == 5'd1)
            && (cal.yr == $past(cal.yr) + 12'd1));

    // R7: captured time matches the write fields
    a_r7_time_capture: assert property (@(posedge clk) disable iff (rst)
        ld_time |=> (tod.hr == $past(bus_wdata[20:16])) && (tod.mn == $past(bus_wdata[13:8]))
                    && (tod.sc == $past(bus_wdata[5:0])));

endmodule

bind cal_clock_top cal_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_1s  (tick_1s),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .paused   (paused),
    .ld_time  (ld_time),
    .day_inc  (day_inc),
    .tod      (tod_q),
    .cal      (cal_q)
);

// File: tb/tb_cal_clock_top.sv
`timescale 1ns/1ps
module tb_cal_clock_top;

    localparam int P = 32'h0100_0000;
    localparam int S = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1s = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr;
    bit m_tf, m_tc, m_df, m_dc;

    cal_clock_top #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic int mlen(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tword(int h, int m, int s);
        return 32'((h << 16) | (m << 8) | s);
    endfunction

    function automatic logic [31:0] dword(int mo, int wd, int d, int y);
        return 32'((mo << 24) | (wd << 21) | (d << 16) | y);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h10) return tword(m_hr, m_min, m_sec);
        if (a == 8'h14) return dword(m_mon, m_wd, m_day, m_yr);
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // behavioural reference, evaluated on each rising edge
    always @(posedge clk) begin
        bit lt, ldd, run, ystep;
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_wd = 1; m_mon = 1; m_yr = 0;
            m_tf = 0; m_tc = 0; m_df = 0; m_dc = 0;
        end else begin
            lt  = bus_we && bus_addr == 8'h00 && bus_wdata[25] && bus_wdata[24] && !m_tc;
            ldd = bus_we && bus_addr == 8'h04 && bus_wdata[25] && bus_wdata[24] && !m_dc;
            run = tick_1s && !(m_tf || m_df) && !lt && !ldd;
            ystep = 0;
            if (run) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hr++;
                        if (m_hr == 24) begin
                            m_hr = 0;
                            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                            m_day++;
                            if (m_day > mlen(m_mon, m_yr)) begin
                                m_day = 1; m_mon++;
                                if (m_mon == 13) begin m_mon = 1; ystep = 1; end
                            end
                        end
                    end
                end
            end
            if (bus_we && bus_addr == 8'h08) m_yr = int'(bus_wdata[11:0]);
            else if (ystep) m_yr = (m_yr + 1) % 4096;
            if (lt) begin
                m_hr = int'(bus_wdata[20:16]); m_min = int'(bus_wdata[13:8]); m_sec = int'(bus_wdata[5:0]);
            end
            if (ldd) begin
                m_mon = int'(bus_wdata[19:16]); m_wd = int'(bus_wdata[10:8]); m_day = int'(bus_wdata[4:0]);
            end
            if (bus_we && bus_addr == 8'h00) begin m_tf = bus_wdata[24]; m_tc = bus_wdata[25]; end
            if (bus_we && bus_addr == 8'h04) begin m_df = bus_wdata[24]; m_dc = bus_wdata[25]; end
        end
    end

    // per-cycle comparison a quarter period after the edge (R2 layouts)
    always @(posedge clk) begin
        #5;
        check("R2 per-cycle read vs model", bus_rdata, model_read(bus_addr));
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h10;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_1s = 1'b1;
            bus_addr = (i % 2 == 0) ? 8'h10 : 8'h14;
        end
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_time(int h, int m, int s, logic [31:0] junk);
        logic [31:0] v;
        v = tword(h, m, s) | junk;
        wr(8'h00, v | P);
        wr(8'h00, v | P | S);
        wr(8'h00, v | P);
        wr(8'h00, v);
    endtask

    task automatic set_date(int mo, int wd, int d);
        logic [31:0] v;
        v = 32'((mo << 16) | (wd << 8) | d);
        wr(8'h04, v | P);
        wr(8'h04, v | P | S);
        wr(8'h04, v | P);
        wr(8'h04, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        rd(8'h10, tword(0, 0, 0), "R1 reset time");
        rd(8'h14, dword(1, 1, 1, 0), "R1 reset date");

        // R3: 61 ticks -> 00:01:01
        ticks(61);
        rd(8'h10, tword(0, 1, 1), "R3 minute carry");

        // R7 / R10: load New Year's Eve
        wr(8'h08, 32'd2023);
        set_date(12, 7, 31);
        set_time(23, 59, 50, 32'h0);
        rd(8'h10, tword(23, 59, 50), "R7 time loaded");
        rd(8'h14, dword(12, 7, 31, 2023), "R7 R10 date and year loaded");

        // R4 / R5: roll into the new year
        ticks(15);
        rd(8'h10, tword(0, 0, 5), "R3 hour wrap");
        rd(8'h14, dword(1, 1, 1, 2024), "R4 R5 new year, weekday 7->1");

        // R6: leap February
        set_date(2, 3, 28);
        set_time(23, 59, 59, 32'h0);
        ticks(1);
        rd(8'h14, dword(2, 4, 29, 2024), "R6 leap Feb 29");
        set_time(23, 59, 59, 32'h0);
        ticks(1);
        rd(8'h14, dword(3, 5, 1, 2024), "R6 leap Feb 29 -> Mar 1");
        wr(8'h08, 32'd2023);
        set_date(2, 2, 28);
        set_time(23, 59, 59, 32'h0);
        ticks(1);
        rd(8'h14, dword(3, 3, 1, 2023), "R6 common Feb 28 -> Mar 1");

        // R5: 30-day month
        set_date(4, 6, 30);
        set_time(23, 59, 59, 32'h0);
        ticks(1);
        rd(8'h14, dword(5, 7, 1, 2023), "R5 Apr 30 -> May 1");

        // R9: freeze holds the clock
        set_time(10, 20, 30, 32'h0);
        wr(8'h00, tword(10, 20, 30) | P);
        ticks(10);
        rd(8'h10, tword(10, 20, 30), "R9 frozen time holds");
        wr(8'h00, tword(1, 1, 1));
        rd(8'h10, tword(10, 20, 30), "R9 write without capture does not load");
        ticks(3);
        rd(8'h10, tword(10, 20, 33), "R9 resumes after freeze clears");

        // R8: repeated capture does not reload
        wr(8'h04, 32'h0003_030A | P);
        wr(8'h04, 32'h0003_030A | P | S);
        wr(8'h04, 32'h0004_0414 | P | S);
        rd(8'h14, dword(3, 3, 10, 2023), "R8 second capture ignored");
        wr(8'h04, 32'h0003_030A | P);
        wr(8'h04, 32'h0003_030A);

        // R11: stray bits in the set word
        set_time(5, 6, 7, 32'hFCE0_C0C0);
        rd(8'h10, tword(5, 6, 7), "R11 stray bits ignored");

        // R2: unmapped and write-only offsets read zero
        rd(8'h00, 32'h0, "R2 time-set reads zero");
        rd(8'h04, 32'h0, "R2 date-set reads zero");
        rd(8'h08, 32'h0, "R2 year reads zero");
        rd(8'h0C, 32'h0, "R2 gap reads zero");
        rd(8'h18, 32'h0, "R2 beyond map reads zero");

        // R10: year write wins over a year carry on the same edge
        wr(8'h08, 32'd100);
        set_date(12, 2, 31);
        set_time(23, 59, 59, 32'h0);
        @(negedge clk);
        tick_1s = 1'b1; bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd777;
        @(negedge clk);
        tick_1s = 1'b0; bus_we = 1'b0;
        rd(8'h14, dword(1, 3, 1, 777), "R10 year write beats carry");

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule